// File: doc/BRIEF.md
# Decimating Averaging Trace Capture

This block records a trace from one signed sample stream into a circular sample memory. It takes one input sample on every clock. Once armed, it waits for a trigger pulse and then stores one point for every 2^e clocks. The exponent e runs from 0 to 16. Each stored point is one of two values, selected by the averaging setting. With averaging off, it is the first raw sample of that window. With averaging on, it is the arithmetic mean of all 2^e samples in the window, formed as a running sum followed by an arithmetic right shift by e.

In single-shot mode, capture stops after one full pass through the memory and raises a done flag. In rolling mode, the write index wraps and capture continues until the host disarms the block. The write index is visible at all times, so software can tell which entries were rewritten while it was reading. A separate random-access read port returns stored points with a fixed latency of two clocks. A full trace is 2^14 = 16384 points, with `ADDR_W` set to 14. The default elaborates a 2^11 memory so that the model stays small.

Top module: `trace_capture`

## Requirements
- R1: After a synchronous active-low reset, `busy` is 0, `done` is 0 and `wr_ptr` is 0.
- R2: A trigger pulse while the block is idle (not armed) has no effect: `busy` stays 0 and `wr_ptr` stays 0.
- R3: An `arm` pulse makes `busy` 1, clears `done` and sets `wr_ptr` to 0. No point is written until a trigger is seen while armed. The first sample taken is the one on the clock after the trigger clock.
- R4: With e = 0, every input sample is stored, at consecutive addresses, and `wr_ptr` advances by one per clock.
- R5: With averaging off and e > 0, point j holds the raw sample taken 2^e·j clocks after the first sample.
- R6: With averaging on, point j equals the signed sum of samples 2^e·j to 2^e·j+2^e−1, shifted arithmetically right by e and rounded toward minus infinity.
- R7: In single-shot mode (`cfg_roll` = 0), capture ends after 2^ADDR_W points. `done` becomes 1, `busy` becomes 0 and `wr_ptr` wraps to 0. Nothing more is written, and `done` stays 1 until the next `arm`.
- R8: In rolling mode (`cfg_roll` = 1), `wr_ptr` wraps from 2^ADDR_W−1 to 0 and capture continues. A `disarm` pulse stops it on the clock where it is seen, with no write on that clock, and `done` stays 0.
- R9: The sum does not overflow at e = 16: its width is the input width plus 16 bits. An average of constant full-scale input returns full scale.
- R10: A read address presented before clock edge k yields its stored point on `rd_data` after edge k+1. After edge k, `rd_data` still shows the previous read.
- R11: `wr_ptr` is always the index of the next point to be written. It changes only on a write (+1, modulo the depth) or on `arm` (to 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, one input sample per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| adc_in | input | DATA_W | Signed input sample stream |
| arm | input | 1 | Pulse: restart and wait for trigger |
| disarm | input | 1 | Pulse: stop capture and return to idle |
| trig | input | 1 | Pulse: start capture when armed |
| cfg_exp | input | EXP_W | Decimation exponent e (clamped to MAX_EXP) |
| cfg_avg | input | 1 | 1 = store window average, 0 = store first raw sample |
| cfg_roll | input | 1 | 1 = rolling mode, 0 = single-shot |
| busy | output | 1 | Armed or capturing |
| done | output | 1 | Single-shot trace complete |
| wr_ptr | output | ADDR_W | Index of the next point to be written |
| rd_addr | input | ADDR_W | Host read address |
| rd_data | output | DATA_W | Stored point, two clocks after address |

## Verification
Some behaviours are checked by assertions on every cycle. These are the write index's step and hold rules, the rule that `done` only coexists with idle, and the stop on the last single-shot write. The rolling wrap that keeps capture alive, the decimation counter staying inside its window, and the average always fitting the output width are checked the same way. Other behaviours need the bench's scenarios. These are the point values for raw, averaged and wide-window decimation, the exact start clock after a trigger, and the ring contents after a disarm past the wrap. The ignored idle trigger and the two-clock read latency also need a scenario.

// File: rtl/trace_capture_pkg.sv
// Shared types for the trace capture block.
package trace_capture_pkg;
    // Capture controller states.
    typedef enum logic [1:0] {
        CAP_IDLE  = 2'd0,
        CAP_ARMED = 2'd1,
        CAP_RUN   = 2'd2
    } cap_state_t;
endpackage

// File: rtl/point_former.sv
// Forms one stored point per 2^e input samples.
// Assumes cfg_exp and cfg_avg are held stable while sample_en is high.
// A restart clears the window so the next enabled sample opens a new one.
module point_former #(
    parameter int DATA_W  = 14,
    parameter int MAX_EXP = 16,
    parameter int EXP_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              sample_en,
    input  logic [DATA_W-1:0] x_in,
    input  logic [EXP_W-1:0]  cfg_exp,
    input  logic              cfg_avg,
    output logic              pt_valid,
    output logic [DATA_W-1:0] pt_data
);
    localparam int SUM_W = DATA_W + MAX_EXP;
    localparam int CNT_W = (MAX_EXP < 1) ? 1 : MAX_EXP;

    logic [EXP_W-1:0]        exp_c;
    logic [CNT_W-1:0]        win_mask;
    logic [CNT_W-1:0]        cnt;
    logic signed [SUM_W-1:0] acc;
    logic signed [SUM_W-1:0] x_ext;
    logic signed [SUM_W-1:0] sum_now;
    logic signed [SUM_W-1:0] shifted;
    logic [DATA_W-1:0]       hold;
    logic                    win_open;
    logic                    win_last;

    // Clamp the exponent to the largest supported window.
    assign exp_c = (cfg_exp > EXP_W'(MAX_EXP)) ? EXP_W'(MAX_EXP) : cfg_exp;

    // Window mask: bit i set when i is below the exponent.
    for (genvar i = 0; i < CNT_W; i++) begin : g_mask
        assign win_mask[i] = (EXP_W'(i) < exp_c);
    end

    assign win_open = (cnt == '0);
    assign win_last = (cnt == win_mask);
    assign x_ext    = {{MAX_EXP{x_in[DATA_W-1]}}, x_in};

    // Running sum: the first sample of a window reloads, the rest add.
    assign sum_now  = win_open ? x_ext : (acc + x_ext);
    assign shifted  = sum_now >>> exp_c;

    // Output select and strobe on the last sample of the window.
    assign pt_valid = sample_en && win_last;
    assign pt_data  = cfg_avg ? shifted[DATA_W-1:0] : (win_open ? x_in : hold);

    // Window counter, sum register and first-sample holder.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt  <= '0;
            acc  <= '0;
            hold <= '0;
        end else if (sample_en) begin
            cnt <= win_last ? '0 : cnt + 1'b1;
            acc <= sum_now;
            if (win_open) hold <= x_in;
        end
    end

    // Counter never leaves the window chosen by the exponent.
    assert_cnt_in_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sample_en |-> ((cnt & ~win_mask) == '0));

    // The mean of in-range samples always fits the output width.
    assert_avg_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pt_valid && cfg_avg) |->
            ((&shifted[SUM_W-1:DATA_W-1]) || !(|shifted[SUM_W-1:DATA_W-1])));
endmodule

// File: rtl/capture_ctrl.sv
// Arming, trigger and stop control plus the write index.
// Assumes arm has priority over disarm, and disarm over a write.
module capture_ctrl
    import trace_capture_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic              disarm,
    input  logic              trig,
    input  logic              cfg_roll,
    input  logic              pt_valid,
    output logic              running,
    output logic              busy,
    output logic              done,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_ptr
);
    localparam logic [ADDR_W-1:0] LAST_IDX = '1;

    cap_state_t state;
    logic       last_write;

    assign running    = (state == CAP_RUN);
    assign busy       = (state != CAP_IDLE);
    assign wr_en      = running && pt_valid && !arm && !disarm;
    assign last_write = wr_en && (wr_ptr == LAST_IDX) && !cfg_roll;

    // State, done flag and write index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= CAP_IDLE;
            done   <= 1'b0;
            wr_ptr <= '0;
        end else if (arm) begin
            state  <= CAP_ARMED;
            done   <= 1'b0;
            wr_ptr <= '0;
        end else if (disarm) begin
            state  <= CAP_IDLE;
        end else begin
            if (state == CAP_ARMED && trig) state <= CAP_RUN;
            if (wr_en) wr_ptr <= wr_ptr + 1'b1;
            if (last_write) begin
                state <= CAP_IDLE;
                done  <= 1'b1;
            end
        end
    end

    assert_ptr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (wr_ptr == ADDR_W'($past(wr_ptr) + 1'b1)));

    assert_ptr_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !arm) |=> $stable(wr_ptr));

    assert_full_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        last_write |=> (done && !busy && wr_ptr == '0));

    assert_done_only_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_roll_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && cfg_roll && wr_ptr == LAST_IDX) |=> (running && wr_ptr == '0 && !done));
endmodule

// File: rtl/sample_ram.sv
// Simple dual-port sample memory: one write port, one read port
// with two registered stages. A read of the address being written
// returns the old content.
module sample_ram #(
    parameter int DATA_W = 14,
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] rd_stage;

    // Write port.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    // Two-stage read pipeline.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_stage <= '0;
            rd_data  <= '0;
        end else begin
            rd_stage <= mem[rd_addr];
            rd_data  <= rd_stage;
        end
    end
endmodule

// File: rtl/trace_capture.sv
// Top of the decimating, averaging trace capture block.
// One sample per clock in; one point per 2^e samples stored in a ring.
// ADDR_W = 14 gives the full 16384-point trace.
module trace_capture #(
    parameter int DATA_W  = 14,
    parameter int ADDR_W  = 11,
    parameter int MAX_EXP = 16,
    localparam int EXP_W  = $clog2(MAX_EXP + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] adc_in,
    input  logic              arm,
    input  logic              disarm,
    input  logic              trig,
    input  logic [EXP_W-1:0]  cfg_exp,
    input  logic              cfg_avg,
    input  logic              cfg_roll,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] wr_ptr,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    logic              running;
    logic              pt_valid;
    logic [DATA_W-1:0] pt_data;
    logic              wr_en;

    point_former #(.DATA_W(DATA_W), .MAX_EXP(MAX_EXP), .EXP_W(EXP_W)) u_form (
        .clk(clk), .rst_n(rst_n), .restart(arm), .sample_en(running),
        .x_in(adc_in), .cfg_exp(cfg_exp), .cfg_avg(cfg_avg),
        .pt_valid(pt_valid), .pt_data(pt_data)
    );

    capture_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .arm(arm), .disarm(disarm), .trig(trig),
        .cfg_roll(cfg_roll), .pt_valid(pt_valid), .running(running),
        .busy(busy), .done(done), .wr_en(wr_en), .wr_ptr(wr_ptr)
    );

    sample_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_ptr),
        .wr_data(pt_data), .rd_addr(rd_addr), .rd_data(rd_data)
    );
endmodule

// File: tb/sim_trace_capture.sv
`timescale 1ns/1ps
module sim_trace_capture;
    localparam int DW = 14;
    localparam int AW = 11;
    localparam int D  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [DW-1:0] adc_in;
    logic          arm = 1'b0, disarm = 1'b0, trig = 1'b0;
    logic [4:0]    cfg_exp = '0;
    logic          cfg_avg = 1'b0, cfg_roll = 1'b0;
    logic          busy, done;
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] rd_data;

    int    total = 0, bad = 0;
    longint cyc = 0;
    int    pat = 0;
    longint tstart = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Stimulus patterns: 0 ramp, 1 full-scale constant, 2 mixed sign.
    function automatic longint gen(int p, longint c);
        if (p == 0) return (c % 4096) - 2048;
        if (p == 1) return 8191;
        return ((c * 37) % 1000) - 600;
    endfunction

    // Expected point j from the requirements (R5, R6).
    function automatic longint expect_pt(int p, longint t0, int e, bit avg, longint j);
        longint n = longint'(1) << e;
        longint s = 0;
        if (!avg) return gen(p, t0 + j * n);
        for (longint i = 0; i < n; i++) s += gen(p, t0 + j * n + i);
        return s >>> e;
    endfunction

    assign adc_in = DW'(gen(pat, cyc));

    trace_capture u0 (
        .clk(clk), .rst_n(rst_n), .adc_in(adc_in), .arm(arm), .disarm(disarm),
        .trig(trig), .cfg_exp(cfg_exp), .cfg_avg(cfg_avg), .cfg_roll(cfg_roll),
        .busy(busy), .done(done), .wr_ptr(wr_ptr), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic chk(bit ok, string req, longint act, longint exp_v);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    task automatic pulse_arm();
        @(negedge clk) arm = 1'b1;
        @(negedge clk) arm = 1'b0;
    endtask

    task automatic pulse_disarm();
        @(negedge clk) disarm = 1'b1;
        @(negedge clk) disarm = 1'b0;
    endtask

    // Trigger seen on the next edge; first sample one clock later (R3).
    task automatic pulse_trig();
        @(negedge clk) begin trig = 1'b1; tstart = cyc + 1; end
        @(negedge clk) trig = 1'b0;
    endtask

    task automatic read_pt(int a, output logic [DW-1:0] v);
        @(negedge clk) rd_addr = AW'(a);
        @(negedge clk);
        @(negedge clk) v = rd_data;
    endtask

    // Compare a span of stored points; mapping from address to point index.
    task automatic check_trace(string req, int e, bit avg, int first, int n, longint w);
        int mism = 0;
        longint a1 = 0, e1 = 0;
        logic [DW-1:0] v;
        for (int a = first; a < first + n; a++) begin
            longint j = (w < 0) ? a : (w - 1 - ((w - 1 - a) % D));
            logic [DW-1:0] ev = DW'(expect_pt(pat, tstart, e, avg, j));
            read_pt(a, v);
            if (v !== ev) begin
                if (mism == 0) begin a1 = longint'($signed(v)); e1 = longint'($signed(ev)); end
                mism++;
            end
        end
        chk(mism == 0, req, a1, e1);
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0, "R1 busy", busy, 0);
        chk(done == 1'b0, "R1 done", done, 0);
        chk(wr_ptr == '0, "R1 wr_ptr", wr_ptr, 0);
    endtask

    task automatic test_idle_trigger();
        pulse_trig();
        repeat (10) @(negedge clk);
        chk(busy == 1'b0, "R2 busy after idle trigger", busy, 0);
        chk(wr_ptr == '0, "R2 wr_ptr after idle trigger", wr_ptr, 0);
    endtask

    task automatic run_single(string req, int p, int e, bit avg);
        int guard = 0;
        @(negedge clk) begin pat = p; cfg_exp = 5'(e); cfg_avg = avg; cfg_roll = 1'b0; end
        pulse_arm();
        chk(busy == 1'b1 && done == 1'b0, "R3 armed", {busy, done}, 2);
        repeat (25) @(negedge clk);
        chk(wr_ptr == '0, "R3 no write before trigger", wr_ptr, 0);
        pulse_trig();
        while (!done && guard < 100000) begin @(negedge clk); guard++; end
        chk(done == 1'b1 && busy == 1'b0, "R7 stop", {done, busy}, 2);
        chk(wr_ptr == '0, "R7 wr_ptr wrapped", wr_ptr, 0);
        repeat (20) @(negedge clk);
        chk(wr_ptr == '0 && done == 1'b1, "R7 nothing more written", wr_ptr, 0);
        check_trace(req, e, avg, 0, D, -1);
    endtask

    task automatic test_read_latency_R10();
        logic [DW-1:0] v;
        logic [DW-1:0] e5 = DW'(expect_pt(pat, tstart, 0, 1'b0, 5));
        logic [DW-1:0] e6 = DW'(expect_pt(pat, tstart, 0, 1'b0, 6));
        read_pt(5, v);
        chk(v === e5, "R10 two-cycle read", v, e5);
        @(negedge clk) rd_addr = AW'(6);
        @(negedge clk);
        chk(rd_data === e5, "R10 old data after one edge", rd_data, e5);
        @(negedge clk);
        chk(rd_data === e6, "R10 new data after two edges", rd_data, e6);
    endtask

    task automatic test_rearm();
        pulse_arm();
        chk(done == 1'b0 && busy == 1'b1 && wr_ptr == '0, "R7 done cleared by arm",
            {done, busy}, 1);
        pulse_disarm();
        chk(busy == 1'b0 && done == 1'b0, "R8 disarm from armed", busy, 0);
    endtask

    task automatic test_roll();
        longint w;
        longint cd;
        logic [AW-1:0] p0;
        @(negedge clk) begin pat = 2; cfg_exp = 5'd0; cfg_avg = 1'b0; cfg_roll = 1'b1; end
        pulse_arm();
        pulse_trig();
        repeat (500) @(negedge clk);
        chk(wr_ptr == AW'(cyc - tstart), "R11 live wr_ptr", wr_ptr, (cyc - tstart) % D);
        repeat (1700) @(negedge clk);
        chk(wr_ptr == AW'(cyc - tstart) && busy, "R8 wrapped and running",
            wr_ptr, (cyc - tstart) % D);
        @(negedge clk) begin disarm = 1'b1; cd = cyc; end
        @(negedge clk) disarm = 1'b0;
        w = cd - tstart;
        chk(wr_ptr == AW'(w), "R8 wr_ptr at disarm", wr_ptr, w % D);
        p0 = wr_ptr;
        repeat (30) @(negedge clk);
        chk(wr_ptr == p0 && busy == 1'b0 && done == 1'b0, "R8 stopped after disarm",
            wr_ptr, p0);
        check_trace("R8 ring contents", 0, 1'b0, 0, D, w);
    endtask

    task automatic test_wide_avg();
        int guard = 0;
        @(negedge clk) begin pat = 1; cfg_exp = 5'd10; cfg_avg = 1'b1; cfg_roll = 1'b1; end
        pulse_arm();
        pulse_trig();
        while (wr_ptr < 3 && guard < 10000) begin @(negedge clk); guard++; end
        pulse_disarm();
        check_trace("R9 full-scale average", 10, 1'b1, 0, 3, -1);
    endtask

    initial begin
        #(4 * 190000);
        chk(1'b0, "watchdog", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        test_reset();
        test_idle_trigger();
        run_single("R4 e=0 raw points", 2, 0, 1'b0);
        test_read_latency_R10();
        test_rearm();
        run_single("R5 e=2 raw points", 0, 2, 1'b0);
        run_single("R6 e=3 averaged points", 2, 3, 1'b1);
        test_roll();
        test_wide_avg();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule